// File: doc/BRIEF.md
# CAN Transmit Mailbox Priority Selector

The block sits between the transmit mailboxes of a CAN controller and its bit engine, and decides which mailbox the engine sends next. Each mailbox supplies four things: a pending flag, a transmit-configured flag, a 29-bit identifier and the IDE and RTR bits. One control input chooses the ordering. In identifier mode the mailbox whose bus arbitration value is numerically lowest wins. In mailbox mode the highest-numbered eligible mailbox wins, and mailbox 0 is left out.

The outputs are registered. While the engine is idle, the selector recomputes the result on every clock and presents a valid flag and a winning index. The engine takes the offer by pulsing `start_i`. From then on the index is frozen until the engine reports `done_i` (frame sent) or `lost_i` (bus arbitration lost). The selector then withdraws the offer for one cycle and resumes recomputing.

Top module: `can_tx_prio_sel`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `busy_o` and `idx_o` are all 0. The ordering mode input (`mode_i`) is expected to be 0 (identifier mode) out of reset.
- R2: A mailbox m is eligible only when `pend_i[m]` and `txcfg_i[m]` are both 1. A mailbox that is pending but not configured for transmission is never selected, whatever its key.
- R3: With `mode_i` = 1 (mailbox mode), the winner is the highest eligible index. Mailbox 0 is never selected in this mode, even if it is the only pending one.
- R4: With `mode_i` = 0 (identifier mode), the winner is the eligible mailbox with the smallest 32-bit key. For an extended frame (IDE = 1) the key, from MSB to LSB, is id[28:18], 1, 1, id[17:0], RTR.
- R5: A standard frame (IDE = 0) carries its 11-bit identifier in id[28:18], and id[17:0] is ignored. Its key, from MSB to LSB, is id[28:18], RTR, 0, eighteen 1s, 1. So a standard frame beats an extended frame with the same base identifier, and a data frame beats a remote frame with the same identifier.
- R6: When two eligible keys are equal, the mailbox with the higher index wins.
- R7: When no mailbox is eligible, `valid_o` is 0 and `idx_o` is 0 on the next cycle.
- R8: While `busy_o` is 0 and no start is taken, `valid_o` and `idx_o` take the result for the inputs sampled at the previous rising clock edge. This is a one-cycle latency.
- R9: A `start_i` pulse while `valid_o` is 1 and `busy_o` is 0 sets `busy_o`. While busy, `valid_o` stays 1 and `idx_o` holds its value, whatever the mailbox inputs and the mode do. A `start_i` while `valid_o` is 0 is ignored.
- R10: `done_i` or `lost_i` while busy clears `busy_o` and `valid_o` on the next cycle. Selection resumes on the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Ordering mode: 0 = identifier, 1 = mailbox number |
| pend_i | input | N_MBOX | Pending flag per mailbox |
| txcfg_i | input | N_MBOX | Configured-for-transmit flag per mailbox |
| id_i | input | N_MBOX*29 | Identifier of mailbox m at bits [m*29 +: 29] |
| ide_i | input | N_MBOX | Extended-frame flag per mailbox |
| rtr_i | input | N_MBOX | Remote-frame flag per mailbox |
| start_i | input | 1 | Engine takes the offered mailbox |
| done_i | input | 1 | Engine finished the frame |
| lost_i | input | 1 | Engine lost bus arbitration |
| valid_o | output | 1 | An offer is present |
| idx_o | output | $clog2(N_MBOX) | Offered mailbox index |
| busy_o | output | 1 | Offer taken and frozen |

## Verification
The bench builds the block with the default 32 mailboxes, so the full five-level compare tree is exercised. Mailbox 31, the top index in mailbox mode, and mailbox 0, which that mode excludes, are both reachable. Directed frames cover:
- a standard frame against an extended frame with the same base identifier;
- a data frame against a remote frame with the same identifier;
- a tie between equal keys;
- a mailbox that is pending but not configured.

A randomized phase switches modes and takes offers mid-stream, and it is compared cycle by cycle against a behavioural model.

// File: rtl/can_tx_prio_pkg.sv
package can_tx_prio_pkg;
  localparam int unsigned ID_W  = 29;
  localparam int unsigned BASE_W = 11;
  localparam int unsigned EXT_W = ID_W - BASE_W;
  localparam int unsigned KEY_W = BASE_W + 2 + EXT_W + 1;
  typedef logic [KEY_W-1:0] arb_key_t;
endpackage

// File: rtl/can_tx_key_build.sv
module can_tx_key_build
  import can_tx_prio_pkg::*;
#(
  parameter int unsigned N_MBOX = 32
) (
  input  logic [N_MBOX*ID_W-1:0]  id_i,
  input  logic [N_MBOX-1:0]       ide_i,
  input  logic [N_MBOX-1:0]       rtr_i,
  input  logic                    zero_i,
  output logic [N_MBOX*KEY_W-1:0] key_o
);
  for (genvar m = 0; m < N_MBOX; m++) begin : g_key
    logic [ID_W-1:0] id;
    arb_key_t        key;
    assign id = id_i[m*ID_W +: ID_W];
    always_comb begin
      if (ide_i[m])
        key = {id[ID_W-1 -: BASE_W], 1'b1, 1'b1, id[EXT_W-1:0], rtr_i[m]};
      else
        // standard frame: pad extended part recessive so it wins over same base
        key = {id[ID_W-1 -: BASE_W], rtr_i[m], 1'b0, {EXT_W{1'b1}}, 1'b1};
    end
    // mailbox mode: all keys equal, tie rule picks highest index
    assign key_o[m*KEY_W +: KEY_W] = zero_i ? '0 : key;
  end
endmodule

// File: rtl/can_tx_arb_tree.sv
module can_tx_arb_tree #(
  parameter int unsigned N_MBOX = 32,
  parameter int unsigned KEY_W  = 32,
  localparam int unsigned IDX_W = $clog2(N_MBOX),
  localparam int unsigned NP    = 1 << IDX_W
) (
  input  logic [N_MBOX-1:0]       vld_i,
  input  logic [N_MBOX*KEY_W-1:0] key_i,
  output logic                    any_o,
  output logic [IDX_W-1:0]        idx_o
);
  // heap layout: node k has children 2k (lower indices) and 2k+1
  logic             nv [2*NP];
  logic [KEY_W-1:0] nk [2*NP];
  logic [IDX_W-1:0] ni [2*NP];

  assign nv[0] = 1'b0;
  assign nk[0] = '0;
  assign ni[0] = '0;

  for (genvar i = 0; i < NP; i++) begin : g_leaf
    if (i < N_MBOX) begin : g_real
      assign nv[NP+i] = vld_i[i];
      assign nk[NP+i] = key_i[i*KEY_W +: KEY_W];
    end else begin : g_pad
      assign nv[NP+i] = 1'b0;
      assign nk[NP+i] = '1;
    end
    assign ni[NP+i] = IDX_W'(i);
  end

  for (genvar k = 1; k < NP; k++) begin : g_node
    logic hi;
    // ties go to the higher-index side
    assign hi    = nv[2*k+1] && (!nv[2*k] || (nk[2*k+1] <= nk[2*k]));
    assign nv[k] = nv[2*k] | nv[2*k+1];
    assign nk[k] = hi ? nk[2*k+1] : nk[2*k];
    assign ni[k] = hi ? ni[2*k+1] : ni[2*k];
  end

  assign any_o = nv[1];
  assign idx_o = nv[1] ? ni[1] : '0;
endmodule

// File: rtl/can_tx_sel_ctrl.sv
module can_tx_sel_ctrl #(
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             any_i,
  input  logic [IDX_W-1:0] win_i,
  input  logic             start_i,
  input  logic             done_i,
  input  logic             lost_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o
);
  logic             valid_q, busy_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      busy_q  <= 1'b0;
      idx_q   <= '0;
    end else if (busy_q) begin
      if (done_i || lost_i) begin
        busy_q  <= 1'b0;
        valid_q <= 1'b0;
      end
    end else if (valid_q && start_i) begin
      busy_q <= 1'b1;
    end else begin
      valid_q <= any_i;
      idx_q   <= win_i;
    end
  end

  assign valid_o = valid_q;
  assign idx_o   = idx_q;
  assign busy_o  = busy_q;
endmodule

// File: rtl/can_tx_prio_sel.sv
module can_tx_prio_sel
  import can_tx_prio_pkg::*;
#(
  parameter int unsigned N_MBOX = 32,
  localparam int unsigned IDX_W = $clog2(N_MBOX)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   mode_i,
  input  logic [N_MBOX-1:0]      pend_i,
  input  logic [N_MBOX-1:0]      txcfg_i,
  input  logic [N_MBOX*ID_W-1:0] id_i,
  input  logic [N_MBOX-1:0]      ide_i,
  input  logic [N_MBOX-1:0]      rtr_i,
  input  logic                   start_i,
  input  logic                   done_i,
  input  logic                   lost_i,
  output logic                   valid_o,
  output logic [IDX_W-1:0]       idx_o,
  output logic                   busy_o
);
  logic [N_MBOX-1:0]       elig;
  logic [N_MBOX*KEY_W-1:0] keys;
  logic                    any;
  logic [IDX_W-1:0]        win;

  for (genvar m = 0; m < N_MBOX; m++) begin : g_elig
    if (m == 0) begin : g_m0
      assign elig[m] = pend_i[m] & txcfg_i[m] & ~mode_i;
    end else begin : g_mn
      assign elig[m] = pend_i[m] & txcfg_i[m];
    end
  end

  can_tx_key_build #(.N_MBOX(N_MBOX)) i_key (
    .id_i   (id_i),
    .ide_i  (ide_i),
    .rtr_i  (rtr_i),
    .zero_i (mode_i),
    .key_o  (keys)
  );

  can_tx_arb_tree #(.N_MBOX(N_MBOX), .KEY_W(KEY_W)) i_tree (
    .vld_i (elig),
    .key_i (keys),
    .any_o (any),
    .idx_o (win)
  );

  can_tx_sel_ctrl #(.IDX_W(IDX_W)) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .any_i   (any),
    .win_i   (win),
    .start_i (start_i),
    .done_i  (done_i),
    .lost_i  (lost_i),
    .valid_o (valid_o),
    .idx_o   (idx_o),
    .busy_o  (busy_o)
  );
endmodule

// File: rtl/can_tx_prio_sel_chk.sv
module can_tx_prio_sel_chk #(
  parameter int unsigned N_MBOX = 32,
  localparam int unsigned IDX_W = $clog2(N_MBOX)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_i,
  input logic [N_MBOX-1:0] pend_i,
  input logic [N_MBOX-1:0] txcfg_i,
  input logic              start_i,
  input logic              done_i,
  input logic              lost_i,
  input logic              valid_o,
  input logic [IDX_W-1:0]  idx_o,
  input logic              busy_o
);
  logic              upd_q, mode_q;
  logic [N_MBOX-1:0] elig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q  <= 1'b0;
      mode_q <= 1'b0;
      elig_q <= '0;
    end else begin
      upd_q  <= !busy_o && !(valid_o && start_i);
      mode_q <= mode_i;
      elig_q <= pend_i & txcfg_i & ~(N_MBOX'(mode_i));
    end
  end

  // R2
  pick_eligible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q && valid_o |-> elig_q[idx_o]);
  // R7
  none_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |-> (valid_o == |elig_q));
  // R3
  mb_zero_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q && valid_o && mode_q |-> idx_o != '0);
  // R3
  mb_highest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q && valid_o && mode_q |-> (elig_q >> idx_o) == N_MBOX'(1));
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_i && !lost_i |=> busy_o && valid_o && $stable(idx_o));
  // R10
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (done_i || lost_i) |=> !busy_o && !valid_o);
  // R9
  busy_needs_offer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(valid_o) && $past(start_i));
endmodule

bind can_tx_prio_sel can_tx_prio_sel_chk #(.N_MBOX(N_MBOX)) i_chk (.*);

// File: tb/test_can_tx_prio_sel.sv
`timescale 1ns/1ps
module test_can_tx_prio_sel;
  localparam int N = 32;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          mode;
  logic [N-1:0]  pend, txcfg, ide, rtr;
  logic [28:0]   idv [N];
  logic [N*29-1:0] id_flat;
  logic          start, done, lost;
  logic          valid;
  logic [IW-1:0] idx;
  logic          busy;

  always_comb for (int m = 0; m < N; m++) id_flat[m*29 +: 29] = idv[m];

  can_tx_prio_sel #(.N_MBOX(N)) i_can_tx_prio_sel (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .pend_i(pend), .txcfg_i(txcfg),
    .id_i(id_flat), .ide_i(ide), .rtr_i(rtr), .start_i(start), .done_i(done),
    .lost_i(lost), .valid_o(valid), .idx_o(idx), .busy_o(busy)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // key per R4/R5, built field by field
  function automatic logic [31:0] key_of(int m);
    logic [10:0] base = idv[m][28:18];
    if (ide[m]) return {base, 2'b11, idv[m][17:0], rtr[m]};
    return {base, rtr[m], 1'b0, {18{1'b1}}, 1'b1};
  endfunction

  function automatic int ref_win(output bit any);
    int best = -1;
    logic [31:0] bk = '0;
    any = 0;
    for (int m = N - 1; m >= 0; m--) begin
      if (!(pend[m] && txcfg[m])) continue;
      if (mode) begin
        if (m == 0) continue;
        any = 1;
        return m;
      end
      if (best < 0 || key_of(m) < bk) begin
        best = m;
        bk = key_of(m);
      end
    end
    if (best >= 0) begin
      any = 1;
      return best;
    end
    return 0;
  endfunction

  // behavioural reference
  bit m_vld, m_busy;
  int m_idx;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vld <= 0; m_busy <= 0; m_idx <= 0;
    end else if (m_busy) begin
      if (done || lost) begin
        m_busy <= 0; m_vld <= 0;
      end
    end else if (m_vld && start) begin
      m_busy <= 1;
    end else begin
      bit a;
      int w;
      w = ref_win(a);
      m_vld <= a;
      m_idx <= w;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(valid == m_vld, "R8 valid", valid, m_vld);
      chk(busy == m_busy, "R9 busy", busy, m_busy);
      chk(int'(idx) == m_idx, mode ? "R3 idx" : "R4 idx", idx, m_idx);
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 100000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic clear_all();
    pend = '0; txcfg = '0; ide = '1; rtr = '0;
    for (int m = 0; m < N; m++) idv[m] = '1;
  endtask

  task automatic settle();  // drive after edge, look after next edge
    @(posedge clk); @(negedge clk);
  endtask

  task automatic expect_out(input string req, input bit v, input int i);
    chk(valid == v, req, valid, v);
    chk(int'(idx) == i, req, idx, i);
  endtask

  initial begin
    mode = 0; start = 0; done = 0; lost = 0;
    clear_all();
    repeat (3) @(negedge clk);
    // R1
    chk(valid == 0 && busy == 0 && idx == 0, "R1 reset", {valid, busy}, 0);
    @(posedge clk); #1 rst_n = 1;

    // R3: highest index in mailbox mode
    @(posedge clk); #1 mode = 1; pend = '1; txcfg = '0;
    txcfg[0] = 1; txcfg[5] = 1; txcfg[17] = 1;
    settle(); expect_out("R3 highest", 1, 17);
    @(posedge clk); #1 txcfg = 32'h1;
    settle(); expect_out("R3 mb0 excluded", 0, 0);
    @(posedge clk); #1 mode = 0;
    settle(); expect_out("R4 mb0 in id mode", 1, 0);

    // R4: lowest key
    @(posedge clk); #1 clear_all();
    pend[3] = 1; txcfg[3] = 1; idv[3] = 29'h100;
    pend[9] = 1; txcfg[9] = 1; ide[9] = 0; idv[9] = {11'h010, 18'h0};
    settle(); expect_out("R4 lowest key", 1, 3);

    // R5: standard beats extended with same base
    @(posedge clk); #1 clear_all();
    pend[4] = 1; txcfg[4] = 1; ide[4] = 0; idv[4] = {11'h055, 18'h0};
    pend[2] = 1; txcfg[2] = 1; idv[2] = {11'h055, 18'h0};
    settle(); expect_out("R5 std over ext", 1, 4);
    // R5: data beats remote
    @(posedge clk); #1 clear_all();
    pend[20] = 1; txcfg[20] = 1; ide[20] = 0; rtr[20] = 1; idv[20] = {11'h123, 18'h0};
    pend[8] = 1;  txcfg[8] = 1;  ide[8] = 0;  idv[8] = {11'h123, 18'h0};
    settle(); expect_out("R5 data over remote", 1, 8);

    // R6: tie goes to higher index
    @(posedge clk); #1 clear_all();
    pend[6] = 1; txcfg[6] = 1; ide[6] = 0; idv[6] = {11'h200, 18'h0};
    pend[12] = 1; txcfg[12] = 1; ide[12] = 0; idv[12] = {11'h200, 18'h0};
    settle(); expect_out("R6 tie", 1, 12);

    // R2: pending but not configured ignored
    @(posedge clk); #1 clear_all();
    pend[10] = 1; idv[10] = '0;
    pend[11] = 1; txcfg[11] = 1; idv[11] = 29'h1000;
    settle(); expect_out("R2 unconfigured", 1, 11);

    // R7: nothing eligible
    @(posedge clk); #1 clear_all(); txcfg = '1;
    settle(); expect_out("R7 none", 0, 0);
    // R9: start with no offer ignored
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
    @(negedge clk); chk(busy == 0, "R9 start ignored", busy, 0);

    // R9/R10: hold and release
    @(posedge clk); #1 mode = 1; pend[5] = 1;
    settle(); expect_out("R8 latency", 1, 5);
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0; pend[30] = 1; mode = 0; idv[30] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 1, "R9 busy", busy, 1); expect_out("R9 hold", 1, 5);
    @(posedge clk); #1 done = 1;
    @(posedge clk); #1 done = 0;
    @(negedge clk); chk(busy == 0, "R10 release", busy, 0); expect_out("R10 release", 0, 5);
    @(posedge clk); @(negedge clk); expect_out("R10 resume", 1, 30);

    // random mix (R8, R9, R10 against the model)
    for (int it = 0; it < 3000; it++) begin
      @(posedge clk); #1;
      if ($urandom_range(0, 7) == 0) mode = $urandom_range(0, 1);
      pend = $urandom & $urandom;
      txcfg = $urandom | $urandom;
      for (int m = 0; m < N; m++) begin
        if ($urandom_range(0, 3) == 0) begin
          idv[m] = {$urandom_range(0, 3), 27'($urandom)};
          ide[m] = $urandom_range(0, 1);
          rtr[m] = $urandom_range(0, 1);
        end
      end
      start = $urandom_range(0, 3) == 0;
      done = $urandom_range(0, 5) == 0;
      lost = $urandom_range(0, 9) == 0;
    end
    @(posedge clk); #1 start = 0; done = 0; lost = 0;
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule